// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Unit

This block holds the data-hazard logic of a five-stage 32-bit integer pipeline. For each of the two ALU operands of the instruction in Execute, it compares the source register index with the destination registers held in the two later pipeline registers. It then picks the value the operand must use: the register-file read, the result one stage ahead (EX/MEM), or the result two stages ahead (MEM/WB). The select is driven out as a 2-bit code, and the resolved operand is driven out next to it. A forwarded value reaches Execute in the same cycle, so forwarding never costs a stall and never waits for writeback.

The same unit also watches the pair of instructions in Decode and Execute. When a load in Execute writes a register that the instruction in Decode reads, the loaded data is not ready in time to forward. The unit then raises a hold signal and a bubble signal. The hold signal freezes the PC and the IF/ID register for one cycle. The bubble signal clears the control bits of ID/EX so that a NOP enters Execute. The whole unit is combinational. None of its inputs carries a stream, so there is no valid/ready handshake and no back-pressure: every output follows the present inputs within the same cycle. Branch flushing and the pipeline registers belong to the surrounding pipeline.

Top module: `hz_fwd_unit`

## Requirements
- R1: With no qualifying producer match, an operand select is 2'b00 and the operand equals its register-file value; the code 2'b11 never appears.
- R2: When EX/MEM writes the register file, its destination is nonzero and it equals the operand's source index, the select is 2'b01 and the operand equals the EX/MEM result.
- R3: When MEM/WB writes the register file, its destination is nonzero, it equals the source index and R2 does not apply, the select is 2'b10 and the operand equals the MEM/WB result.
- R4: When both EX/MEM and MEM/WB qualify for the same source, EX/MEM (2'b01) wins.
- R5: A producer whose destination is register 0 is never forwarded, even with its write enable set.
- R6: A producer whose write enable is low is never forwarded; when EX/MEM is disabled, a matching MEM/WB still forwards.
- R7: A load in ID/EX with nonzero destination equal to either Decode source index raises both the front-end hold and the ID/EX bubble in the same cycle.
- R8: The hold and the bubble stay low when the ID/EX instruction is not a load, when its destination is register 0, or when neither Decode source matches.
- R9: Each operand is resolved from its own source index only; the two selects are independent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a | input | 5 | First source register index of the Execute instruction |
| ex_src_b | input | 5 | Second source register index of the Execute instruction |
| rf_val_a | input | 32 | Register-file value read for operand A |
| rf_val_b | input | 32 | Register-file value read for operand B |
| exm_dst | input | 5 | Destination index held in EX/MEM |
| exm_we | input | 1 | EX/MEM instruction writes the register file |
| exm_val | input | 32 | Result held in EX/MEM |
| mwb_dst | input | 5 | Destination index held in MEM/WB |
| mwb_we | input | 1 | MEM/WB instruction writes the register file |
| mwb_val | input | 32 | Result held in MEM/WB |
| dec_src_a | input | 5 | First source index of the Decode instruction |
| dec_src_b | input | 5 | Second source index of the Decode instruction |
| idex_dst | input | 5 | Destination index held in ID/EX |
| idex_load | input | 1 | ID/EX instruction is a load |
| sel_a | output | 2 | Operand A source: 00 register file, 01 EX/MEM, 10 MEM/WB |
| sel_b | output | 2 | Operand B source, same encoding |
| opnd_a | output | 32 | Resolved operand A |
| opnd_b | output | 32 | Resolved operand B |
| hold_front | output | 1 | Freeze PC and IF/ID this cycle |
| bubble_idex | output | 1 | Clear ID/EX control bits to a NOP |

## Verification
The checker tests on every input change that each operand matches the source its select names, that 2'b11 never appears, that a disabled producer or one targeting register 0 is never chosen, that MEM/WB is never chosen over a qualifying EX/MEM, and that hold and bubble move together and stay low without a load. Only the bench scenarios show that a real match actually produces forwarding or a stall. They also show that the two operands resolve independently, that MEM/WB takes over when EX/MEM is disabled, and that a load to register 0 or with no matching source leaves the front end running.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_EXM = 2'b01,
    SRC_MWB = 2'b10
  } fwd_src_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] exm_dst,
  input  logic          exm_we,
  input  logic [AW-1:0] mwb_dst,
  input  logic          mwb_we,
  output fwd_src_e      sel
);
  logic exm_hit, mwb_hit;

  assign exm_hit = exm_we && (exm_dst != '0) && (exm_dst == src);
  assign mwb_hit = mwb_we && (mwb_dst != '0) && (mwb_dst == src);

  // younger producer takes priority
  always_comb begin
    if (exm_hit)      sel = SRC_EXM;
    else if (mwb_hit) sel = SRC_MWB;
    else              sel = SRC_RF;
  end
endmodule

// File: rtl/hz_operand_mux.sv
module hz_operand_mux
  import hz_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  fwd_src_e        sel,
  input  logic [XLEN-1:0] rf_val,
  input  logic [XLEN-1:0] exm_val,
  input  logic [XLEN-1:0] mwb_val,
  output logic [XLEN-1:0] opnd
);
  always_comb begin
    unique case (sel)
      SRC_EXM: opnd = exm_val;
      SRC_MWB: opnd = mwb_val;
      default: opnd = rf_val;
    endcase
  end
endmodule

// File: rtl/hz_loaduse_detect.sv
module hz_loaduse_detect #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] idex_dst,
  input  logic          idex_load,
  input  logic [AW-1:0] dec_src_a,
  input  logic [AW-1:0] dec_src_b,
  output logic          hold_front,
  output logic          bubble_idex
);
  logic dst_live, src_match, hazard;

  assign dst_live  = idex_load && (idex_dst != '0);
  assign src_match = (idex_dst == dec_src_a) || (idex_dst == dec_src_b);
  assign hazard    = dst_live && src_match;

  assign hold_front  = hazard;
  assign bubble_idex = hazard;
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic [AW-1:0]   ex_src_a,
  input  logic [AW-1:0]   ex_src_b,
  input  logic [XLEN-1:0] rf_val_a,
  input  logic [XLEN-1:0] rf_val_b,
  input  logic [AW-1:0]   exm_dst,
  input  logic            exm_we,
  input  logic [XLEN-1:0] exm_val,
  input  logic [AW-1:0]   mwb_dst,
  input  logic            mwb_we,
  input  logic [XLEN-1:0] mwb_val,
  input  logic [AW-1:0]   dec_src_a,
  input  logic [AW-1:0]   dec_src_b,
  input  logic [AW-1:0]   idex_dst,
  input  logic            idex_load,
  output logic [1:0]      sel_a,
  output logic [1:0]      sel_b,
  output logic [XLEN-1:0] opnd_a,
  output logic [XLEN-1:0] opnd_b,
  output logic            hold_front,
  output logic            bubble_idex
);
  localparam int NOPND = 2;

  logic [AW-1:0]   src_arr  [NOPND];
  logic [XLEN-1:0] rf_arr   [NOPND];
  logic [XLEN-1:0] opnd_arr [NOPND];
  fwd_src_e        sel_arr  [NOPND];

  assign src_arr[0] = ex_src_a;
  assign src_arr[1] = ex_src_b;
  assign rf_arr[0]  = rf_val_a;
  assign rf_arr[1]  = rf_val_b;

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    hz_fwd_sel #(.AW(AW)) i_sel (
      .src     (src_arr[g]),
      .exm_dst (exm_dst),
      .exm_we  (exm_we),
      .mwb_dst (mwb_dst),
      .mwb_we  (mwb_we),
      .sel     (sel_arr[g])
    );

    hz_operand_mux #(.XLEN(XLEN)) i_mux (
      .sel     (sel_arr[g]),
      .rf_val  (rf_arr[g]),
      .exm_val (exm_val),
      .mwb_val (mwb_val),
      .opnd    (opnd_arr[g])
    );
  end

  assign sel_a  = sel_arr[0];
  assign sel_b  = sel_arr[1];
  assign opnd_a = opnd_arr[0];
  assign opnd_b = opnd_arr[1];

  hz_loaduse_detect #(.AW(AW)) i_lu (
    .idex_dst    (idex_dst),
    .idex_load   (idex_load),
    .dec_src_a   (dec_src_a),
    .dec_src_b   (dec_src_b),
    .hold_front  (hold_front),
    .bubble_idex (bubble_idex)
  );
endmodule

// File: rtl/hz_fwd_unit_chk.sv
module hz_fwd_unit_chk #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input logic [AW-1:0]   ex_src_a,
  input logic [AW-1:0]   ex_src_b,
  input logic [XLEN-1:0] rf_val_a,
  input logic [XLEN-1:0] rf_val_b,
  input logic [AW-1:0]   exm_dst,
  input logic            exm_we,
  input logic [XLEN-1:0] exm_val,
  input logic [AW-1:0]   mwb_dst,
  input logic            mwb_we,
  input logic [XLEN-1:0] mwb_val,
  input logic [AW-1:0]   dec_src_a,
  input logic [AW-1:0]   dec_src_b,
  input logic [AW-1:0]   idex_dst,
  input logic            idex_load,
  input logic [1:0]      sel_a,
  input logic [1:0]      sel_b,
  input logic [XLEN-1:0] opnd_a,
  input logic [XLEN-1:0] opnd_b,
  input logic            hold_front,
  input logic            bubble_idex
);
  logic exm_q_a, exm_q_b;
  assign exm_q_a = exm_we && (exm_dst != '0) && (exm_dst == ex_src_a);
  assign exm_q_b = exm_we && (exm_dst != '0) && (exm_dst == ex_src_b);

  always_comb begin
    // R1
    sel_legal_chk: assert (sel_a != 2'b11 && sel_b != 2'b11)
      else $error("illegal select code");
    // R1
    rf_path_chk: assert ((sel_a != 2'b00 || opnd_a == rf_val_a) &&
                         (sel_b != 2'b00 || opnd_b == rf_val_b))
      else $error("operand differs from register file on select 00");
    // R2
    exm_path_chk: assert ((sel_a != 2'b01 || opnd_a == exm_val) &&
                          (sel_b != 2'b01 || opnd_b == exm_val))
      else $error("operand differs from EX/MEM on select 01");
    // R3
    mwb_path_chk: assert ((sel_a != 2'b10 || opnd_a == mwb_val) &&
                          (sel_b != 2'b10 || opnd_b == mwb_val))
      else $error("operand differs from MEM/WB on select 10");
    // R4
    exm_priority_chk: assert ((sel_a != 2'b10 || !exm_q_a) &&
                              (sel_b != 2'b10 || !exm_q_b))
      else $error("MEM/WB chosen over qualifying EX/MEM");
    // R5
    zero_dst_chk: assert ((exm_dst != '0 || (sel_a != 2'b01 && sel_b != 2'b01)) &&
                          (mwb_dst != '0 || (sel_a != 2'b10 && sel_b != 2'b10)))
      else $error("register 0 forwarded");
    // R6
    no_write_chk: assert ((exm_we || (sel_a != 2'b01 && sel_b != 2'b01)) &&
                          (mwb_we || (sel_a != 2'b10 && sel_b != 2'b10)))
      else $error("disabled producer forwarded");
    // R7
    hold_bubble_pair_chk: assert (hold_front == bubble_idex)
      else $error("hold and bubble disagree");
    // R8
    no_load_no_hold_chk: assert (idex_load || !hold_front)
      else $error("hold raised without a load");
    // R8
    zero_load_chk: assert (idex_dst != '0 || !hold_front)
      else $error("hold raised for load to register 0");
    // R8
    no_match_chk: assert (!hold_front || idex_dst == dec_src_a || idex_dst == dec_src_b)
      else $error("hold raised with no matching source");
  end
endmodule

bind hz_fwd_unit hz_fwd_unit_chk #(.XLEN(XLEN), .AW(AW)) i_chk (.*);

// File: tb/test_hz_fwd_unit.sv
module test_hz_fwd_unit;
  localparam int XLEN = 32;
  localparam int AW   = 5;
  localparam logic [XLEN-1:0] RFA = 32'h1111_0001;
  localparam logic [XLEN-1:0] RFB = 32'h2222_0002;
  localparam logic [XLEN-1:0] EXV = 32'hAAAA_000E;
  localparam logic [XLEN-1:0] MWV = 32'h5555_000B;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0]   ex_src_a, ex_src_b, exm_dst, mwb_dst, dec_src_a, dec_src_b, idex_dst;
  logic            exm_we, mwb_we, idex_load;
  logic [XLEN-1:0] rf_val_a, rf_val_b, exm_val, mwb_val;
  logic [1:0]      sel_a, sel_b;
  logic [XLEN-1:0] opnd_a, opnd_b;
  logic            hold_front, bubble_idex;

  hz_fwd_unit #(.XLEN(XLEN), .AW(AW)) i_hz_fwd_unit (.*);

  typedef struct {
    string           tag;
    logic [1:0]      sa, sb;
    logic [XLEN-1:0] oa, ob;
    logic            hold;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  function automatic logic [XLEN-1:0] pick(logic [1:0] s, logic [XLEN-1:0] rf);
    return (s == 2'b01) ? EXV : (s == 2'b10) ? MWV : rf;
  endfunction

  task automatic send(string tag,
                      int sa_i, int sb_i, int ed, bit ew, int md, bit mw,
                      int da, int db, int ld, bit ll,
                      logic [1:0] esa, logic [1:0] esb, logic eh);
    exp_t e;
    @(posedge clk);
    #1;
    ex_src_a = AW'(sa_i); ex_src_b = AW'(sb_i);
    exm_dst = AW'(ed); exm_we = ew;
    mwb_dst = AW'(md); mwb_we = mw;
    dec_src_a = AW'(da); dec_src_b = AW'(db);
    idex_dst = AW'(ld); idex_load = ll;
    e.tag = tag; e.sa = esa; e.sb = esb;
    e.oa = pick(esa, RFA); e.ob = pick(esb, RFB); e.hold = eh;
    sb_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (sel_a !== e.sa || sel_b !== e.sb || opnd_a !== e.oa || opnd_b !== e.ob ||
          hold_front !== e.hold || bubble_idex !== e.hold) begin
        n_fail++;
        $display("FAIL %s: got sel=%b/%b op=%h/%h hold=%b bub=%b, exp sel=%b/%b op=%h/%h hold=%b bub=%b",
                 e.tag, sel_a, sel_b, opnd_a, opnd_b, hold_front, bubble_idex,
                 e.sa, e.sb, e.oa, e.ob, e.hold, e.hold);
      end
    end
  end

  initial begin
    rf_val_a = RFA; rf_val_b = RFB; exm_val = EXV; mwb_val = MWV;
    //    tag             sa sb ed ew md mw da db ld ll   exp a  exp b  hold
    send("R1 idle",        0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, 1'b0);
    send("R1 no match",    3, 4, 5, 1, 6, 1, 1, 2, 7, 0, 2'b00, 2'b00, 1'b0);
    send("R2 exm on a",    3, 4, 3, 1, 6, 1, 1, 2, 7, 0, 2'b01, 2'b00, 1'b0);
    send("R2 exm on b",    3, 4, 4, 1, 6, 1, 1, 2, 7, 0, 2'b00, 2'b01, 1'b0);
    send("R3 mwb on a",    7, 4, 5, 1, 7, 1, 1, 2, 7, 0, 2'b10, 2'b00, 1'b0);
    send("R4 both match",  9, 9, 9, 1, 9, 1, 1, 2, 7, 0, 2'b01, 2'b01, 1'b0);
    send("R9 split srcs",  3, 4, 3, 1, 4, 1, 1, 2, 7, 0, 2'b01, 2'b10, 1'b0);
    send("R5 dst zero",    0, 0, 0, 1, 0, 1, 1, 2, 7, 0, 2'b00, 2'b00, 1'b0);
    send("R6 exm off",     3, 4, 3, 0, 3, 1, 1, 2, 7, 0, 2'b10, 2'b00, 1'b0);
    send("R6 both off",    3, 4, 3, 0, 4, 0, 1, 2, 7, 0, 2'b00, 2'b00, 1'b0);
    send("R7 load src a",  1, 2, 0, 0, 0, 0, 8, 2, 8, 1, 2'b00, 2'b00, 1'b1);
    send("R7 load src b",  1, 2, 0, 0, 0, 0, 1, 8, 8, 1, 2'b00, 2'b00, 1'b1);
    send("R8 not load",    1, 2, 0, 0, 0, 0, 8, 8, 8, 0, 2'b00, 2'b00, 1'b0);
    send("R8 load x0",     1, 2, 0, 0, 0, 0, 0, 0, 0, 1, 2'b00, 2'b00, 1'b0);
    send("R8 load nomatch",1, 2, 0, 0, 0, 0, 1, 2, 8, 1, 2'b00, 2'b00, 1'b0);
    send("R7 with bypass", 5, 6, 5, 1, 6, 1, 9, 3, 3, 1, 2'b01, 2'b10, 1'b1);
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule